// File: doc/BRIEF.md
# Paged PC and Memory Address Generator

This block produces the program counter and the memory address of a 16-bit machine whose memory is divided into 512-word pages. A page number comes from the upper seven bits of a word address. The offset inside the page comes from the lower nine bits. From the PC, the instruction word, a register-file value and the shared bus value, the block forms several candidate addresses. Two control selects then choose among them.

The next-PC selector can pick the sequential successor, an in-page jump target, a register-file value or the bus value. The PC register takes the selected value only on cycles when the load enable is high. The memory-address selector is combinational. It can pick a page-relative direct address, a base register plus an unsigned offset, or a zero-extended trap vector. The direct candidate is also the value that a load-effective-address operation writes back. That operation does not touch memory.

The PC register always holds the already-incremented PC of the instruction being executed. For this reason, page-relative targets take their page number from the page the incremented PC has reached.

Top module: `pgaddr_gen`

## Requirements
- R1: While the active-low reset `rst_n` is low, and on the first cycle after it is released, `pc` equals 16'h3000.
- R2: When `pc_load` is 0, `pc` keeps its value at the clock edge, whatever the values of `pc_sel`, `instr`, `base_val` and `bus_val`.
- R3: When `pc_load` is 1 and `pc_sel` = 2'b00, `pc` becomes `pc` + 1 modulo 2^16, so 16'hFFFF is followed by 16'h0000.
- R4: When `pc_load` is 1 and `pc_sel` = 2'b01, `pc` becomes {pc[15:9], instr[8:0]}. The page bits are those of the current PC register, which is already incremented. A step from 16'h31FF to 16'h3200 therefore moves later targets into page 7'h19.
- R5: When `pc_load` is 1, `pc_sel` = 2'b10 loads `base_val` into `pc` and `pc_sel` = 2'b11 loads `bus_val` into `pc`.
- R6: When `addr_sel` = 2'b00, `mem_addr` equals {pc[15:9], instr[8:0]} in the same cycle. This is also the load-effective-address value.
- R7: When `addr_sel` = 2'b01, `mem_addr` equals `base_val` plus instr[5:0] zero-extended, modulo 2^16. instr[15:6] has no effect on the result.
- R8: When `addr_sel` = 2'b10, `mem_addr` equals instr[7:0] zero-extended to 16 bits. instr[15:8] has no effect on the result.
- R9: The reserved code `addr_sel` = 2'b11 gives the same address as 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_load | input | 1 | PC register write enable |
| pc_sel | input | 2 | Next-PC source: 00 increment, 01 page target, 10 register value, 11 bus |
| addr_sel | input | 2 | Address source: 00 page direct, 01 base+offset, 10 trap vector, 11 as 00 |
| instr | input | 16 | Current instruction word |
| base_val | input | 16 | Register-file read value |
| bus_val | input | 16 | Shared bus value |
| pc | output | 16 | Current program counter |
| mem_addr | output | 16 | Selected memory address |

## Verification
The bench builds the block with its default widths: a 16-bit address, a 9-bit page offset, a 6-bit base offset and an 8-bit trap vector. With these widths, every page offset, every base offset against several bases (including bases that wrap past 16'hFFFF) and every trap vector can be swept exhaustively. The instruction bits outside each field are filled with changing patterns, which shows that those bits are ignored. A PC step across the 16'h31FF/16'h3200 page edge tests the requirement that page-relative addresses use the incremented PC.

// File: rtl/pgaddr_pkg.sv
package pgaddr_pkg;
  // Next-PC source codes
  typedef enum logic [1:0] {
    PC_STEP = 2'b00,
    PC_PAGE = 2'b01,
    PC_REGV = 2'b10,
    PC_BUSV = 2'b11
  } pc_src_e;

  // Memory address source codes
  typedef enum logic [1:0] {
    AD_PAGE = 2'b00,
    AD_BASE = 2'b01,
    AD_TRAP = 2'b10,
    AD_RSVD = 2'b11
  } addr_src_e;
endpackage

// File: rtl/pg_cand.sv
// Builds every candidate address from PC, instruction fields and base value.
module pg_cand #(
  parameter int AW  = 16,
  parameter int PW  = 9,
  parameter int BOW = 6,
  parameter int TW  = 8
) (
  input  logic [AW-1:0] pc,
  input  logic [PW-1:0] ifield,
  input  logic [AW-1:0] base_val,
  output logic [AW-1:0] step_addr,
  output logic [AW-1:0] page_addr,
  output logic [AW-1:0] base_addr,
  output logic [AW-1:0] trap_addr
);
  localparam int PGW = AW - PW;

  function automatic logic [AW-1:0] f_step(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] f_page(input logic [AW-1:0] p,
                                           input logic [PW-1:0] off);
    return {p[AW-1 -: PGW], off};
  endfunction

  function automatic logic [AW-1:0] f_base(input logic [AW-1:0] b,
                                           input logic [BOW-1:0] off);
    return b + {{(AW-BOW){1'b0}}, off};
  endfunction

  function automatic logic [AW-1:0] f_trap(input logic [TW-1:0] vec);
    return {{(AW-TW){1'b0}}, vec};
  endfunction

  assign step_addr = f_step(pc);
  assign page_addr = f_page(pc, ifield);
  assign base_addr = f_base(base_val, ifield[BOW-1:0]);
  assign trap_addr = f_trap(ifield[TW-1:0]);
endmodule

// File: rtl/pg_pc_reg.sv
// Next-PC selection and the PC register.
module pg_pc_reg
  import pgaddr_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  pc_src_e       sel,
  input  logic [AW-1:0] step_addr,
  input  logic [AW-1:0] page_addr,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] bus_val,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] next_pc
);
  always_comb begin
    unique case (sel)
      PC_STEP: next_pc = step_addr;
      PC_PAGE: next_pc = page_addr;
      PC_REGV: next_pc = reg_val;
      PC_BUSV: next_pc = bus_val;
      default: next_pc = step_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= AW'(RESET_PC);
    else if (load) pc <= next_pc;
  end
endmodule

// File: rtl/pg_addr_mux.sv
// Memory address selection; reserved code falls back to page-direct.
module pg_addr_mux
  import pgaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  addr_src_e     sel,
  input  logic [AW-1:0] page_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] trap_addr,
  output logic [AW-1:0] mem_addr
);
  always_comb begin
    unique case (sel)
      AD_PAGE: mem_addr = page_addr;
      AD_BASE: mem_addr = base_addr;
      AD_TRAP: mem_addr = trap_addr;
      AD_RSVD: mem_addr = page_addr;
      default: mem_addr = page_addr;
    endcase
  end
endmodule

// File: rtl/pgaddr_gen.sv
module pgaddr_gen
  import pgaddr_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          IW       = 16,
  parameter int          PW       = 9,
  parameter int          BOW      = 6,
  parameter int          TW       = 8,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_load,
  input  logic [1:0]    pc_sel,
  input  logic [1:0]    addr_sel,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] bus_val,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mem_addr
);
  // Named internal events for the checker
  logic [AW-1:0] step_addr;
  logic [AW-1:0] page_addr;
  logic [AW-1:0] base_addr;
  logic [AW-1:0] trap_addr;
  logic [AW-1:0] next_pc;
  logic          instr_hi_unused;

  assign instr_hi_unused = ^instr[IW-1:PW];

  pg_cand #(.AW(AW), .PW(PW), .BOW(BOW), .TW(TW)) u_cand (
    .pc        (pc),
    .ifield    (instr[PW-1:0]),
    .base_val  (base_val),
    .step_addr (step_addr),
    .page_addr (page_addr),
    .base_addr (base_addr),
    .trap_addr (trap_addr)
  );

  pg_pc_reg #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pc_load),
    .sel       (pc_src_e'(pc_sel)),
    .step_addr (step_addr),
    .page_addr (page_addr),
    .reg_val   (base_val),
    .bus_val   (bus_val),
    .pc        (pc),
    .next_pc   (next_pc)
  );

  pg_addr_mux #(.AW(AW)) u_amux (
    .sel       (addr_src_e'(addr_sel)),
    .page_addr (page_addr),
    .base_addr (base_addr),
    .trap_addr (trap_addr),
    .mem_addr  (mem_addr)
  );
endmodule

// File: rtl/pgaddr_gen_chk.sv
module pgaddr_gen_chk #(
  parameter int          AW       = 16,
  parameter int          IW       = 16,
  parameter int          PW       = 9,
  parameter int          TW       = 8,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pc_load,
  input logic [1:0]    pc_sel,
  input logic [1:0]    addr_sel,
  input logic [IW-1:0] instr,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] bus_val,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] page_addr
);
  p_reset_pc_r1: assert property (@(posedge clk) $rose(rst_n) |-> pc == AW'(RESET_PC));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |=> $stable(pc));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_sel == 2'b00) |=> pc == AW'($past(pc) + AW'(1)));

  p_page_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_sel == 2'b01) |=> pc[AW-1:PW] == $past(pc[AW-1:PW]));

  p_regv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_sel == 2'b10) |=> pc == $past(base_val));

  p_busv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_sel == 2'b11) |=> pc == $past(bus_val));

  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel == 2'b00 |-> (mem_addr[AW-1:PW] == pc[AW-1:PW] &&
                           mem_addr[PW-1:0] == instr[PW-1:0]));

  p_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel == 2'b10 |-> (mem_addr[AW-1:TW] == '0 && mem_addr[TW-1:0] == instr[TW-1:0]));

  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel == 2'b11 |-> mem_addr == page_addr);
endmodule

bind pgaddr_gen pgaddr_gen_chk #(
  .AW(AW), .IW(IW), .PW(PW), .TW(TW), .RESET_PC(RESET_PC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc_load   (pc_load),
  .pc_sel    (pc_sel),
  .addr_sel  (addr_sel),
  .instr     (instr),
  .base_val  (base_val),
  .bus_val   (bus_val),
  .pc        (pc),
  .mem_addr  (mem_addr),
  .page_addr (page_addr)
);

// File: tb/test_pgaddr_gen.sv
module test_pgaddr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_load;
  logic [1:0]  pc_sel;
  logic [1:0]  addr_sel;
  logic [15:0] instr;
  logic [15:0] base_val;
  logic [15:0] bus_val;
  logic [15:0] pc;
  logic [15:0] mem_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgaddr_gen i_pgaddr_gen (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_sel(pc_sel),
    .addr_sel(addr_sel), .instr(instr), .base_val(base_val),
    .bus_val(bus_val), .pc(pc), .mem_addr(mem_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at falling edge, clock once, sample at next falling edge.
  task automatic step_pc(input logic ld, input logic [1:0] sel, input logic [15:0] ins,
                         input logic [15:0] bv, input logic [15:0] busv);
    @(negedge clk);
    pc_load = ld; pc_sel = sel; instr = ins; base_val = bv; bus_val = busv;
    @(posedge clk);
    @(negedge clk);
    pc_load = 1'b0;
  endtask

  function automatic logic [15:0] exp_page(input logic [15:0] p, input logic [15:0] ins);
    return 16'((p / 512) * 512 + (ins % 512));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [15:0] bases [4];
    bases[0] = 16'h0000; bases[1] = 16'h1234; bases[2] = 16'hFFC1; bases[3] = 16'hFFFF;

    rst_n = 1'b0; pc_load = 1'b0; pc_sel = 2'b00; addr_sel = 2'b00;
    instr = 16'h0; base_val = 16'h0; bus_val = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", pc, 16'h3000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pc, 16'h3000);

    // R2: no load, every select and noisy data
    for (int s = 0; s < 4; s++) begin
      step_pc(1'b0, 2'(s), 16'hA5A5 ^ 16'(s), 16'h7777, 16'h9999);
      chk("R2 hold without load", pc, 16'h3000);
    end

    // R3: increments and wrap
    step_pc(1'b1, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R3 step", pc, 16'h3001);
    step_pc(1'b1, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R3 step", pc, 16'h3002);
    step_pc(1'b1, 2'b11, 16'h0, 16'h0, 16'hFFFF);
    chk("R5 bus load", pc, 16'hFFFF);
    step_pc(1'b1, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R3 wrap", pc, 16'h0000);

    // R5: register-file load
    step_pc(1'b1, 2'b10, 16'h0, 16'hBEEF, 16'h1111);
    chk("R5 reg load", pc, 16'hBEEF);

    // R4: page boundary after increment
    step_pc(1'b1, 2'b11, 16'h0, 16'h0, 16'h31FF);
    step_pc(1'b1, 2'b00, 16'h0, 16'h0, 16'h0);
    chk("R4 step across page", pc, 16'h3200);
    @(negedge clk);
    addr_sel = 2'b00; instr = 16'hF045;
    #1 chk("R6 direct uses incremented page", mem_addr, 16'h3245);
    step_pc(1'b1, 2'b01, 16'hF045, 16'h0, 16'h0);
    chk("R4 page jump in new page", pc, 16'h3245);
    step_pc(1'b1, 2'b01, 16'h01FF, 16'h0, 16'h0);
    chk("R4 page jump top offset", pc, 16'h33FF);

    // R6 / R9: every page offset, noisy upper bits, two PC values
    held = pc;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      instr = 16'((i * 37 % 128) * 512 + i);
      addr_sel = 2'b00;
      #1 chk("R6 direct sweep", mem_addr, exp_page(held, instr));
      addr_sel = 2'b11;
      #1 chk("R9 reserved as direct", mem_addr, exp_page(held, instr));
    end
    step_pc(1'b1, 2'b11, 16'h0, 16'h0, 16'hFE10);
    held = pc;
    for (int i = 0; i < 512; i += 7) begin
      @(negedge clk);
      instr = 16'(i); addr_sel = 2'b00;
      #1 chk("R6 direct top page", mem_addr, exp_page(held, instr));
    end

    // R7: base plus every unsigned offset, with wrap
    for (int b = 0; b < 4; b++) begin
      for (int o = 0; o < 64; o++) begin
        @(negedge clk);
        base_val = bases[b];
        instr = 16'((o * 53 + b) % 1024) * 64 + 16'(o);
        addr_sel = 2'b01;
        #1 chk("R7 base offset", mem_addr, 16'((32'(bases[b]) + o) % 65536));
      end
    end

    // R8: every trap vector, noisy upper byte
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      instr = 16'(((v * 29 + 3) % 256) * 256 + v);
      addr_sel = 2'b10;
      #1 chk("R8 trap vector", mem_addr, 16'(v));
    end

    // R2: address select activity does not move the PC
    @(negedge clk);
    chk("R2 pc unchanged by address sweeps", pc, 16'hFE10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule